// File: doc/BRIEF.md
# Interrupt Pending State Controller

This block holds the pending state of every interrupt in a small distributor that feeds several processor interfaces. The interrupt space has two parts. The low identifiers are software-generated interrupts (SGIs), which one processor sends to a set of target processors. The remaining identifiers are peripheral interrupts, each driven by a hardware line. Each peripheral interrupt is configured as edge-triggered or level-sensitive.

For a peripheral interrupt, a latched pending flop is kept apart from the recorded level of its line. The latch is set by a rising edge (edge mode only) or by a set-pending write. It is cleared by a clear-pending write or an acknowledge. The reported pending status is the latch ORed with the line level when the interrupt is level-sensitive. A software clear therefore cannot hide an asserted level line, and a software set outlives the line.

For an SGI, the block keeps one bit per source processor for each pairing of SGI number and target processor. An acknowledge by the target reports the lowest-numbered source that has signalled, one cycle later, and retires that single source bit. The SGI stays pending while any source bit remains.

Top module: `irq_pend_ctrl`

## Requirements
- R1: While `rst_ni` is low at a rising clock edge, every latch, recorded line level and SGI source bit is cleared. From the next cycle all of `per_pend_o`, `sgi_pend_o`, `ack_src_vld_o` and `ack_src_o` read zero.
- R2: Each cycle the block records every line level. Bit i of `per_pend_o` equals the latch of peripheral i ORed with (bit i of `trig_edge_i` is 0, meaning level-sensitive, AND the recorded level is 1).
- R3: An edge-triggered peripheral (`trig_edge_i` bit = 1) whose line is sampled high after being sampled low sets its latch. `per_pend_o` shows it one cycle after that edge.
- R4: A level-sensitive peripheral with no latch shows pending one cycle after its line is sampled high, and stops one cycle after the line is sampled low. A rising edge does not set its latch.
- R5: A line being sampled low leaves the latch unchanged, so an edge-triggered interrupt stays pending after its line drops.
- R6: A clear-pending write (`clr_wr_i` with `wr_mask_i` bit i) clears only the latch. A level-sensitive peripheral whose line is still high stays pending.
- R7: A set-pending write (`set_wr_i` with `wr_mask_i` bit i) sets the latch. A level-sensitive peripheral then stays pending after its line drops, until a clear or an acknowledge.
- R8: In one cycle, a set-pending write or an edge capture takes precedence over a clear-pending write or an acknowledge of the same peripheral. The latch ends up set.
- R9: An acknowledge with `ack_id_i` = NUM_SGI + i clears the latch of peripheral i. The next cycle `ack_src_vld_o` is 0 and `ack_src_o` is 0.
- R10: A raise (`sgi_req_i`) with source s, number n and target mask m sets source bit s of pairing (t, n) for every t with bit t of m set. `sgi_pend_o[t*NUM_SGI + n]` is 1 while any source bit of that pairing is set.
- R11: An acknowledge by processor t of an identifier n < NUM_SGI whose pairing has source bits set does two things on the next cycle. It gives `ack_src_vld_o` = 1 with `ack_src_o` = the lowest-numbered set source, and it clears only that source bit.
- R12: An acknowledge of an SGI pairing with no source bits set gives `ack_src_vld_o` = 0 and `ack_src_o` = 0 on the next cycle and changes no state.
- R13: A raise of source bit s in the same cycle as an acknowledge that retires bit s of the same pairing leaves the bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Synchronous reset, active low |
| line_i | input | NUM_IRQ-NUM_SGI | Peripheral interrupt lines |
| trig_edge_i | input | NUM_IRQ-NUM_SGI | Trigger mode per peripheral: 1 edge, 0 level |
| set_wr_i | input | 1 | Set-pending write strobe |
| clr_wr_i | input | 1 | Clear-pending write strobe |
| wr_mask_i | input | NUM_IRQ-NUM_SGI | Peripheral mask for set and clear writes |
| sgi_req_i | input | 1 | SGI raise strobe |
| sgi_src_i | input | clog2(NUM_CPU) | Raising processor |
| sgi_id_i | input | clog2(NUM_SGI) | SGI number |
| sgi_tgt_i | input | NUM_CPU | Target processor mask |
| ack_i | input | 1 | Acknowledge strobe |
| ack_cpu_i | input | clog2(NUM_CPU) | Acknowledging processor |
| ack_id_i | input | clog2(NUM_IRQ) | Acknowledged identifier |
| per_pend_o | output | NUM_IRQ-NUM_SGI | Effective peripheral pending status |
| sgi_pend_o | output | NUM_CPU*NUM_SGI | SGI pending per target, index t*NUM_SGI+n |
| ack_src_vld_o | output | 1 | Reported SGI source is valid (one cycle after acknowledge) |
| ack_src_o | output | clog2(NUM_CPU) | Reported SGI source processor |

## Verification
The peripheral assertions take the trigger mode of an interrupt to hold steady while its state is live. A property that looks one cycle ahead could otherwise see a level interrupt turn into an edge interrupt. The bench sets `trig_edge_i` once, before reset is released: the lower half of the peripherals is edge-triggered and the upper half level-sensitive. It never changes the mode afterwards, including during the randomised phase. The SGI assertions assume that an acknowledge names one processor and one identifier per cycle, and the one-hot source decode guarantees that each raise touches only one source bit.

// File: rtl/irq_pend_pkg.sv
package irq_pend_pkg;

   typedef enum logic {
      TRIG_LEVEL = 1'b0,
      TRIG_EDGE  = 1'b1
   } trig_mode_e;

   localparam int unsigned DEF_NUM_IRQ = 32;
   localparam int unsigned DEF_NUM_SGI = 16;
   localparam int unsigned DEF_NUM_CPU = 4;

endpackage

// File: rtl/irq_pend_cell.sv
module irq_pend_cell
   import irq_pend_pkg::*;
(
   input  logic clk_i,
   input  logic rst_ni,
   input  logic line_i,
   input  logic edge_mode_i,
   input  logic set_i,
   input  logic clr_i,
   input  logic ack_i,
   output logic pend_o
);

   logic lat_q;
   logic lvl_q;
   logic rise;
   logic is_edge;

   assign is_edge = (trig_mode_e'(edge_mode_i) == TRIG_EDGE);
   assign rise    = line_i & ~lvl_q;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         lat_q <= 1'b0;
         lvl_q <= 1'b0;
      end else begin
         lvl_q <= line_i;
         lat_q <= set_i | (is_edge & rise) | (lat_q & ~clr_i & ~ack_i);
      end
   end

   assign pend_o = lat_q | (~is_edge & lvl_q);

   a_r3_edge_capture : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (is_edge && rise) |=> lat_q);

   a_r5_fall_keeps_latch : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (lvl_q && !line_i && !set_i && !clr_i && !ack_i) |=> (lat_q == $past(lat_q)));

   a_r6_level_survives_clear : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_i && !set_i && !is_edge && line_i) |=> (pend_o || edge_mode_i));

   a_r7_set_sticks : assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i |=> pend_o);

   a_r8_edge_beats_clear : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (is_edge && rise && (clr_i || ack_i)) |=> lat_q);

endmodule

// File: rtl/irq_sgi_src_cell.sv
module irq_sgi_src_cell #(
   parameter int unsigned NUM_CPU = irq_pend_pkg::DEF_NUM_CPU,
   localparam int unsigned CPU_W  = $clog2(NUM_CPU)
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic [NUM_CPU-1:0] raise_i,
   input  logic               ack_i,
   output logic               any_o,
   output logic [CPU_W-1:0]   low_o
);

   logic [NUM_CPU-1:0] src_q;
   logic [NUM_CPU-1:0] retire;
   logic [CPU_W-1:0]   low;

   always_comb begin
      low = '0;
      for (int s = NUM_CPU - 1; s >= 0; s--) begin
         if (src_q[s]) low = CPU_W'(s);
      end
   end

   assign any_o  = |src_q;
   assign low_o  = low;
   assign retire = (ack_i && any_o) ? (NUM_CPU'(1) << low) : '0;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) src_q <= '0;
      else         src_q <= raise_i | (src_q & ~retire);
   end

   a_r10_raise_sets : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (raise_i != '0) |=> ((src_q & $past(raise_i)) == $past(raise_i)));

   a_r11_retire_one : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ack_i && any_o && raise_i == '0) |=> ($countones(src_q) + 1 == $countones($past(src_q))));

   a_r11_lowest_pick : assert property (@(posedge clk_i) disable iff (!rst_ni)
      any_o |-> (src_q[low_o] && ((src_q & ((NUM_CPU'(1) << low_o) - NUM_CPU'(1))) == '0)));

   a_r12_empty_ack_idle : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ack_i && !any_o && raise_i == '0) |=> !any_o);

endmodule

// File: rtl/irq_pend_ctrl.sv
module irq_pend_ctrl
   import irq_pend_pkg::*;
#(
   parameter int unsigned NUM_IRQ = DEF_NUM_IRQ,
   parameter int unsigned NUM_SGI = DEF_NUM_SGI,
   parameter int unsigned NUM_CPU = DEF_NUM_CPU,
   localparam int unsigned NUM_PER = NUM_IRQ - NUM_SGI,
   localparam int unsigned CPU_W   = $clog2(NUM_CPU),
   localparam int unsigned SGI_W   = $clog2(NUM_SGI),
   localparam int unsigned ID_W    = $clog2(NUM_IRQ),
   localparam int unsigned NUM_PAIR = NUM_CPU * NUM_SGI
) (
   input  logic                clk_i,
   input  logic                rst_ni,
   input  logic [NUM_PER-1:0]  line_i,
   input  logic [NUM_PER-1:0]  trig_edge_i,
   input  logic                set_wr_i,
   input  logic                clr_wr_i,
   input  logic [NUM_PER-1:0]  wr_mask_i,
   input  logic                sgi_req_i,
   input  logic [CPU_W-1:0]    sgi_src_i,
   input  logic [SGI_W-1:0]    sgi_id_i,
   input  logic [NUM_CPU-1:0]  sgi_tgt_i,
   input  logic                ack_i,
   input  logic [CPU_W-1:0]    ack_cpu_i,
   input  logic [ID_W-1:0]     ack_id_i,
   output logic [NUM_PER-1:0]  per_pend_o,
   output logic [NUM_PAIR-1:0] sgi_pend_o,
   output logic                ack_src_vld_o,
   output logic [CPU_W-1:0]    ack_src_o
);

   if (NUM_CPU < 2) begin : g_bad_cpu
      $error("irq_pend_ctrl: NUM_CPU must be at least 2");
   end
   if (NUM_SGI < 2 || NUM_SGI >= NUM_IRQ) begin : g_bad_sgi
      $error("irq_pend_ctrl: NUM_SGI must be in [2, NUM_IRQ)");
   end

   logic               ack_sgi;
   logic [NUM_PAIR-1:0] pair_ack;
   logic [CPU_W-1:0]   pair_low [NUM_PAIR];
   logic               sel_any;
   logic [CPU_W-1:0]   sel_low;
   logic               vld_q;
   logic [CPU_W-1:0]   src_q;

   assign ack_sgi = ack_i && (ack_id_i < ID_W'(NUM_SGI));

   for (genvar i = 0; i < NUM_PER; i++) begin : g_per
      logic per_ack;
      assign per_ack = ack_i && (ack_id_i == ID_W'(NUM_SGI + i));
      irq_pend_cell u_cell (
         .clk_i       (clk_i),
         .rst_ni      (rst_ni),
         .line_i      (line_i[i]),
         .edge_mode_i (trig_edge_i[i]),
         .set_i       (set_wr_i & wr_mask_i[i]),
         .clr_i       (clr_wr_i & wr_mask_i[i]),
         .ack_i       (per_ack),
         .pend_o      (per_pend_o[i])
      );
   end

   for (genvar t = 0; t < NUM_CPU; t++) begin : g_tgt
      for (genvar n = 0; n < NUM_SGI; n++) begin : g_sgi
         logic [NUM_CPU-1:0] raise;
         for (genvar s = 0; s < NUM_CPU; s++) begin : g_src
            assign raise[s] = sgi_req_i && sgi_tgt_i[t] &&
                              (sgi_id_i == SGI_W'(n)) && (sgi_src_i == CPU_W'(s));
         end
         assign pair_ack[t*NUM_SGI+n] = ack_sgi && (ack_cpu_i == CPU_W'(t)) &&
                                        (ack_id_i == ID_W'(n));
         irq_sgi_src_cell #(.NUM_CPU(NUM_CPU)) u_src (
            .clk_i   (clk_i),
            .rst_ni  (rst_ni),
            .raise_i (raise),
            .ack_i   (pair_ack[t*NUM_SGI+n]),
            .any_o   (sgi_pend_o[t*NUM_SGI+n]),
            .low_o   (pair_low[t*NUM_SGI+n])
         );
      end
   end

   always_comb begin
      sel_any = 1'b0;
      sel_low = '0;
      for (int p = 0; p < NUM_PAIR; p++) begin
         if (pair_ack[p]) begin
            sel_any = sgi_pend_o[p];
            sel_low = pair_low[p];
         end
      end
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         vld_q <= 1'b0;
         src_q <= '0;
      end else begin
         vld_q <= sel_any;
         src_q <= sel_any ? sel_low : '0;
      end
   end

   assign ack_src_vld_o = vld_q;
   assign ack_src_o     = src_q;

   a_r9_periph_ack_silent : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ack_i && !ack_sgi) |=> (!ack_src_vld_o && ack_src_o == '0));

   a_r11_ack_reports : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ack_sgi && sel_any) |=> ack_src_vld_o);

   a_r12_invalid_zero : assert property (@(posedge clk_i) disable iff (!rst_ni)
      !ack_src_vld_o |-> (ack_src_o == '0));

   a_r10_one_ack_pair : assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0(pair_ack));

endmodule

// File: tb/sim_irq_pend_ctrl.sv
module sim_irq_pend_ctrl;

   localparam int NIRQ = 32;
   localparam int NSGI = 16;
   localparam int NCPU = 4;
   localparam int NPER = NIRQ - NSGI;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [NPER-1:0] line = '0, trig = '0, mask = '0;
   logic set_wr = 0, clr_wr = 0, sgi_req = 0, ack = 0;
   logic [1:0] sgi_src = 0, ack_cpu = 0;
   logic [3:0] sgi_id = 0;
   logic [NCPU-1:0] sgi_tgt = 0;
   logic [4:0] ack_id = 0;
   logic [NPER-1:0] per_pend;
   logic [NCPU*NSGI-1:0] sgi_pend;
   logic ack_vld;
   logic [1:0] ack_src;

   always #2 clk = ~clk;

   irq_pend_ctrl u0 (
      .clk_i(clk), .rst_ni(rst_n), .line_i(line), .trig_edge_i(trig),
      .set_wr_i(set_wr), .clr_wr_i(clr_wr), .wr_mask_i(mask),
      .sgi_req_i(sgi_req), .sgi_src_i(sgi_src), .sgi_id_i(sgi_id), .sgi_tgt_i(sgi_tgt),
      .ack_i(ack), .ack_cpu_i(ack_cpu), .ack_id_i(ack_id),
      .per_pend_o(per_pend), .sgi_pend_o(sgi_pend),
      .ack_src_vld_o(ack_vld), .ack_src_o(ack_src)
   );

   // reference state
   bit m_lat [NPER];
   bit m_lvl [NPER];
   bit [NCPU-1:0] m_src [NCPU][NSGI];
   bit m_vld;
   int m_srcv;
   int n_checks = 0, n_fail = 0;
   bit finished = 0;

   task automatic model_step();
      int t, n, low;
      bit hit;
      if (!rst_n) begin
         for (int i = 0; i < NPER; i++) begin m_lat[i] = 0; m_lvl[i] = 0; end
         for (int a = 0; a < NCPU; a++) for (int b = 0; b < NSGI; b++) m_src[a][b] = '0;
         m_vld = 0; m_srcv = 0;
         return;
      end
      // acknowledge report and retire (uses old state)
      m_vld = 0; m_srcv = 0;
      t = int'(ack_cpu); n = int'(ack_id);
      low = -1;
      if (ack && n < NSGI) begin
         for (int s = NCPU - 1; s >= 0; s--) if (m_src[t][n][s]) low = s;
         if (low >= 0) begin m_vld = 1; m_srcv = low; end
      end
      for (int i = 0; i < NPER; i++) begin
         bit rise;
         rise = line[i] && !m_lvl[i];
         hit  = ack && (int'(ack_id) == NSGI + i);
         if ((set_wr && mask[i]) || (trig[i] && rise)) m_lat[i] = 1;
         else if ((clr_wr && mask[i]) || hit) m_lat[i] = 0;
         m_lvl[i] = line[i];
      end
      if (low >= 0) m_src[t][n][low] = 0;
      if (sgi_req)
         for (int a = 0; a < NCPU; a++)
            if (sgi_tgt[a]) m_src[a][sgi_id][sgi_src] = 1;
   endtask

   task automatic compare(string tag);
      logic [NPER-1:0] e_per;
      logic [NCPU*NSGI-1:0] e_sgi;
      for (int i = 0; i < NPER; i++) e_per[i] = m_lat[i] || (!trig[i] && m_lvl[i]);
      for (int a = 0; a < NCPU; a++)
         for (int b = 0; b < NSGI; b++) e_sgi[a*NSGI+b] = (m_src[a][b] != '0);
      n_checks++;
      if (per_pend !== e_per || sgi_pend !== e_sgi || ack_vld !== m_vld ||
          ack_src !== 2'(m_srcv)) begin
         n_fail++;
         $display("FAIL %s: per=%h sgi=%h vld=%b src=%0d expected per=%h sgi=%h vld=%b src=%0d",
                  tag, per_pend, sgi_pend, ack_vld, ack_src, e_per, e_sgi, m_vld, m_srcv);
      end
   endtask

   task automatic cyc(string tag);
      @(posedge clk);
      model_step();
      @(negedge clk);
      compare(tag);
      set_wr = 0; clr_wr = 0; sgi_req = 0; ack = 0; mask = '0;
   endtask

   task automatic expect_bit(string tag, logic act, logic exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %b expected %b", tag, act, exp);
      end
   endtask

   task automatic raise(int src, int id, logic [NCPU-1:0] tgt);
      sgi_req = 1; sgi_src = 2'(src); sgi_id = 4'(id); sgi_tgt = tgt;
   endtask

   task automatic do_ack(int cpu, int id);
      ack = 1; ack_cpu = 2'(cpu); ack_id = 5'(id);
   endtask

   initial begin
      #(200000 * 4);
      if (!finished) begin
         n_fail++;
         $display("FAIL watchdog: actual hung expected done");
         $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      trig = 16'h00FF;   // peripherals 0..7 edge, 8..15 level
      @(negedge clk);
      line = 16'hFFFF;   // held during reset: must not leave state behind
      cyc("R1"); cyc("R1");
      line = '0;
      cyc("R1");
      rst_n = 1;
      cyc("R1");
      expect_bit("R1", ack_vld, 1'b0);

      // R3 / R5: edge peripheral 0
      line[0] = 1; cyc("R3");
      expect_bit("R3", per_pend[0], 1'b1);
      line[0] = 0; cyc("R5"); cyc("R5");
      expect_bit("R5", per_pend[0], 1'b1);

      // R4: level peripheral 8
      line[8] = 1; cyc("R4");
      expect_bit("R4", per_pend[8], 1'b1);
      line[8] = 0; cyc("R4");
      expect_bit("R4", per_pend[8], 1'b0);

      // R6: clear on level peripheral 9 with line high
      line[9] = 1; cyc("R6");
      clr_wr = 1; mask[9] = 1; cyc("R6");
      expect_bit("R6", per_pend[9], 1'b1);
      line[9] = 0; cyc("R6");
      expect_bit("R6", per_pend[9], 1'b0);

      // R7: set on level peripheral 10 outlives the line
      line[10] = 1; cyc("R7");
      set_wr = 1; mask[10] = 1; cyc("R7");
      line[10] = 0; cyc("R7"); cyc("R7");
      expect_bit("R7", per_pend[10], 1'b1);
      clr_wr = 1; mask[10] = 1; cyc("R7");
      expect_bit("R7", per_pend[10], 1'b0);

      // R8: precedence
      set_wr = 1; clr_wr = 1; mask[1] = 1; cyc("R8");
      expect_bit("R8", per_pend[1], 1'b1);
      line[2] = 1; do_ack(0, NSGI + 2); cyc("R8");
      expect_bit("R8", per_pend[2], 1'b1);
      line[2] = 0;

      // R9: peripheral acknowledge
      do_ack(1, NSGI + 0); cyc("R9");
      expect_bit("R9", per_pend[0], 1'b0);
      expect_bit("R9", ack_vld, 1'b0);

      // R10: SGI raises
      raise(2, 5, 4'b1010); cyc("R10");
      raise(1, 5, 4'b0010); cyc("R10");
      expect_bit("R10", sgi_pend[1*NSGI+5], 1'b1);
      expect_bit("R10", sgi_pend[0*NSGI+5], 1'b0);

      // R11: lowest source first, one at a time
      do_ack(1, 5); cyc("R11");
      expect_bit("R11", ack_vld, 1'b1);
      expect_bit("R11", ack_src == 2'd1, 1'b1);
      expect_bit("R11", sgi_pend[1*NSGI+5], 1'b1);
      do_ack(1, 5); cyc("R11");
      expect_bit("R11", ack_src == 2'd2, 1'b1);
      expect_bit("R11", sgi_pend[1*NSGI+5], 1'b0);

      // R12: empty acknowledge
      do_ack(1, 5); cyc("R12");
      expect_bit("R12", ack_vld, 1'b0);
      expect_bit("R12", sgi_pend[3*NSGI+5], 1'b1);

      // R13: raise and retire of the same bit in one cycle
      raise(3, 7, 4'b0001); cyc("R13");
      raise(3, 7, 4'b0001); do_ack(0, 7); cyc("R13");
      expect_bit("R13", ack_vld, 1'b1);
      expect_bit("R13", sgi_pend[0*NSGI+7], 1'b1);

      // R2: randomised mix against the reference model
      for (int k = 0; k < 3000; k++) begin
         line = 16'($urandom);
         if ($urandom_range(0, 3) == 0) begin set_wr = 1; mask = 16'($urandom); end
         if ($urandom_range(0, 3) == 0) begin clr_wr = 1; mask = mask | 16'($urandom); end
         if ($urandom_range(0, 2) == 0) raise($urandom_range(0, 3), $urandom_range(0, 15), 4'($urandom));
         if ($urandom_range(0, 2) == 0) do_ack($urandom_range(0, 3), $urandom_range(0, 31));
         cyc("R2");
      end

      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end

endmodule